// File: doc/BRIEF.md
# Asynchronous SRAM Access Controller

This block lets synchronous logic read and write an external asynchronous byte-wide static RAM. A client raises a read or write request together with a 15-bit word address and, for writes, an 8-bit data byte. The controller registers the address and data, then runs a fixed sequence of bus cycles. During each sequence it drives the memory's address lines, its data lines with their drive enable, and active-high output-enable, write-enable and chip-enable. Chip-enable stays asserted at all times. The top address bit is tied to a constant level chosen by a parameter, so the logic reaches one half of a 64K x 8 part.

A write takes three cycles. In the first cycle the address and data are presented with the strobe low. In the second cycle the strobe is asserted. In the third cycle the strobe is released while the address and data are still held. Because the address and data come from registers that load only when a request is accepted, they cannot change while the strobe is high, including between clock edges. A read holds output-enable high for two cycles by default, or for one cycle if a parameter selects it. The read byte is captured into a holding register on the last edge of the read.

When a sequence ends, `done` pulses for one cycle and `busy` drops. A new request can be accepted in that same cycle. Requests that arrive while `busy` is high are ignored.

Top module: `sram_access_ctrl`

## Requirements
- R1: While reset is held and after it is released, with no request: `busy`, `done`, `mem_oe`, `mem_we` and `mem_dq_drv` are 0, `rd_data` is 0x00, and `mem_ce` is 1.
- R2: A write accepted on edge E0 gives three bus cycles: after E0 the strobe is low, after E0+1 it is high, and after E0+2 it is low again. `mem_dq_drv` is 1 in all three cycles.
- R3: During a write, `mem_addr[14:0]` equals the request address and `mem_dq_out` equals the request data in all three cycles. Neither changes at any time while `mem_we` is 1.
- R4: A read accepted on edge E0, with the default two-cycle read, holds `mem_oe` at 1 in the two cycles after E0 and E0+1. The address is on `mem_addr[14:0]` in both cycles. `rd_data` takes the bus value sampled on edge E0+2.
- R5: `mem_oe` and `mem_we` are never both 1. `mem_dq_drv` is 0 whenever `mem_oe` is 1 and outside write sequences.
- R6: `wr_req` and `rd_req` raised while `busy` is 1 are ignored. The address and data on the bus, the sequence length and the memory contents are unaffected.
- R7: If `wr_req` and `rd_req` are both 1 in an idle cycle, the write is performed.
- R8: `rd_data` holds its value until the next read completes. It is unchanged by writes.
- R9: `mem_ce` is always 1 and `mem_addr[15]` always equals the parameter `HI_ADDR_LEVEL` (default 0).
- R10: `busy` is 1 from the accepting edge through the last bus cycle. `done` is 1 for exactly the one cycle after that, with `busy` 0. A request presented in the `done` cycle is accepted.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| rd_req | input | 1 | Start a read (sampled while idle) |
| wr_req | input | 1 | Start a write (sampled while idle, wins over read) |
| req_addr | input | 15 | Word address of the request |
| req_wdata | input | 8 | Byte to write |
| mem_addr | output | 16 | Registered memory address, bit 15 constant |
| mem_dq_out | output | 8 | Data driven toward the memory |
| mem_dq_drv | output | 1 | Drive enable for `mem_dq_out` |
| mem_dq_in | input | 8 | Data returned by the memory |
| mem_oe | output | 1 | Output enable, active high |
| mem_we | output | 1 | Write strobe, active high |
| mem_ce | output | 1 | Chip enable, active high, always 1 |
| rd_data | output | 8 | Last byte read |
| done | output | 1 | One-cycle pulse when a sequence ends |
| busy | output | 1 | Sequence in progress |

## Verification
The bench drives each request half a cycle before edge E0 and samples every output at the falling edge that follows each later rising edge. Write bus cycles are checked after E0, E0+1 and E0+2, and `done` after E0+3. Read bus cycles are checked after E0 and E0+1, with `done` and `rd_data` after E0+2. Any skew of one cycle in a strobe, a capture or the done pulse therefore fails a named check. The memory model also counts every change of address or data seen while the strobe is high, including changes between edges. It returns data shortly after the address settles, so a read that samples too early or a write that lands at the wrong address shows up in later readbacks.

// File: rtl/sram_ctrl_pkg.sv
// Package: shared state indices for the SRAM access sequencer.
// Assumes a one-hot state vector of SEQ_NUM_ST bits.
package sram_ctrl_pkg;
    localparam int SEQ_NUM_ST = 6;
    localparam int ST_IDLE    = 0;  // waiting for a request
    localparam int ST_W_SET   = 1;  // write: address/data set up, strobe low
    localparam int ST_W_STB   = 2;  // write: strobe high
    localparam int ST_W_HLD   = 3;  // write: strobe low, address/data held
    localparam int ST_R_SET   = 4;  // read: first output-enable cycle
    localparam int ST_R_SMP   = 5;  // read: last cycle, capture at its end
    typedef logic [SEQ_NUM_ST-1:0] seq_state_t;
endpackage

// File: rtl/sram_seq_fsm.sv
// Module: sram_seq_fsm
// Sequencer for asynchronous SRAM accesses. It accepts a request only while
// idle and steps a one-hot state through the write or read sequence. Every
// memory control line comes straight from its own flop, so the outputs
// cannot glitch when the state changes.
// Assumes: the requests are synchronous to clk. TWO_CYCLE_RD selects a
// read that is two cycles long (1) or one cycle long (0).
module sram_seq_fsm
    import sram_ctrl_pkg::*;
#(
    parameter bit TWO_CYCLE_RD = 1'b1
) (
    input  logic clk,
    input  logic rst_n,
    input  logic rd_req,
    input  logic wr_req,
    output logic ld_addr,
    output logic ld_wdata,
    output logic cap_rd,
    output logic oe_q,
    output logic we_q,
    output logic drv_q,
    output logic done_q,
    output logic busy
);
    seq_state_t st_q, st_d;
    logic       accept;

    // Qualify a request: only taken while idle.
    always_comb begin
        accept   = st_q[ST_IDLE] && (rd_req || wr_req);
        ld_addr  = accept;
        ld_wdata = st_q[ST_IDLE] && wr_req;
        cap_rd   = st_q[ST_R_SMP];
        busy     = !st_q[ST_IDLE];
    end

    // Next-state decode; write wins when both requests arrive together.
    always_comb begin
        st_d = '0;
        unique case (1'b1)
            st_q[ST_IDLE]: begin
                if (wr_req)
                    st_d[ST_W_SET] = 1'b1;
                else if (rd_req)
                    st_d[TWO_CYCLE_RD ? ST_R_SET : ST_R_SMP] = 1'b1;
                else
                    st_d[ST_IDLE] = 1'b1;
            end
            st_q[ST_W_SET]: st_d[ST_W_STB] = 1'b1;
            st_q[ST_W_STB]: st_d[ST_W_HLD] = 1'b1;
            st_q[ST_W_HLD]: st_d[ST_IDLE]  = 1'b1;
            st_q[ST_R_SET]: st_d[ST_R_SMP] = 1'b1;
            st_q[ST_R_SMP]: st_d[ST_IDLE]  = 1'b1;
            default:        st_d[ST_IDLE]  = 1'b1;
        endcase
    end

    // State register and registered control outputs.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st_q   <= seq_state_t'(1) << ST_IDLE;
            oe_q   <= 1'b0;
            we_q   <= 1'b0;
            drv_q  <= 1'b0;
            done_q <= 1'b0;
        end else begin
            st_q   <= st_d;
            oe_q   <= st_d[ST_R_SET] || st_d[ST_R_SMP];
            we_q   <= st_d[ST_W_STB];
            drv_q  <= st_d[ST_W_SET] || st_d[ST_W_STB] || st_d[ST_W_HLD];
            done_q <= st_q[ST_W_HLD] || st_q[ST_R_SMP];
        end
    end
endmodule

// File: rtl/sram_addr_data_reg.sv
// Module: sram_addr_data_reg
// Holds the memory address and the write byte for the whole sequence. The
// registers load only on the edge that accepts a request, so their outputs
// stay constant while the write strobe is high.
// Assumes: ld_wdata is asserted only together with ld_addr.
module sram_addr_data_reg #(
    parameter int ADDR_W = 15,
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              ld_addr,
    input  logic              ld_wdata,
    input  logic [ADDR_W-1:0] addr_in,
    input  logic [DATA_W-1:0] wdata_in,
    output logic [ADDR_W-1:0] addr_q,
    output logic [DATA_W-1:0] wdata_q
);
    // Address register, loaded when any request is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)       addr_q <= '0;
        else if (ld_addr) addr_q <= addr_in;
    end

    // Write-data register, loaded only when a write is accepted.
    always_ff @(posedge clk) begin
        if (!rst_n)        wdata_q <= '0;
        else if (ld_wdata) wdata_q <= wdata_in;
    end
endmodule

// File: rtl/sram_rd_capture.sv
// Module: sram_rd_capture
// Captures the memory data bus on the last edge of a read and holds the
// value until the next read completes.
// Assumes: the memory data is valid before the capturing edge, which the
// output-enable cycle or cycles guarantee.
module sram_rd_capture #(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              cap,
    input  logic [DATA_W-1:0] dq_in,
    output logic [DATA_W-1:0] rd_q
);
    // Holding register for the read byte.
    always_ff @(posedge clk) begin
        if (!rst_n)   rd_q <= '0;
        else if (cap) rd_q <= dq_in;
    end
endmodule

// File: rtl/sram_access_ctrl.sv
// Module: sram_access_ctrl (top)
// Connects the sequencer, the address/data registers and the read capture.
// It adds the constant top address bit and the constant chip enable.
// Assumes: the pad inversion and the tri-state buffer live outside this
// block. mem_dq_drv enables the external driver of mem_dq_out.
module sram_access_ctrl #(
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 8,
    parameter bit HI_ADDR_LEVEL = 1'b0,
    parameter bit TWO_CYCLE_RD  = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              rd_req,
    input  logic              wr_req,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic [DATA_W-1:0] req_wdata,
    output logic [ADDR_W:0]   mem_addr,
    output logic [DATA_W-1:0] mem_dq_out,
    output logic              mem_dq_drv,
    input  logic [DATA_W-1:0] mem_dq_in,
    output logic              mem_oe,
    output logic              mem_we,
    output logic              mem_ce,
    output logic [DATA_W-1:0] rd_data,
    output logic              done,
    output logic              busy
);
    logic              ld_addr, ld_wdata, cap_rd;
    logic [ADDR_W-1:0] addr_q;

    sram_seq_fsm #(.TWO_CYCLE_RD(TWO_CYCLE_RD)) seq_i (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
        .ld_addr(ld_addr), .ld_wdata(ld_wdata), .cap_rd(cap_rd),
        .oe_q(mem_oe), .we_q(mem_we), .drv_q(mem_dq_drv),
        .done_q(done), .busy(busy)
    );

    sram_addr_data_reg #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) adr_i (
        .clk(clk), .rst_n(rst_n), .ld_addr(ld_addr), .ld_wdata(ld_wdata),
        .addr_in(req_addr), .wdata_in(req_wdata),
        .addr_q(addr_q), .wdata_q(mem_dq_out)
    );

    sram_rd_capture #(.DATA_W(DATA_W)) cap_i (
        .clk(clk), .rst_n(rst_n), .cap(cap_rd),
        .dq_in(mem_dq_in), .rd_q(rd_data)
    );

    // Constant top address bit and permanently enabled chip.
    always_comb begin
        mem_addr = {HI_ADDR_LEVEL, addr_q};
        mem_ce   = 1'b1;
    end
endmodule

// File: rtl/sram_access_ctrl_chk.sv
// Module: sram_access_ctrl_chk
// Property checker for sram_access_ctrl, attached to it by bind below.
module sram_access_ctrl_chk #(
    parameter int ADDR_W        = 15,
    parameter int DATA_W        = 8,
    parameter bit HI_ADDR_LEVEL = 1'b0
) (
    input logic              clk,
    input logic              rst_n,
    input logic [ADDR_W:0]   mem_addr,
    input logic [DATA_W-1:0] mem_dq_out,
    input logic              mem_dq_drv,
    input logic              mem_oe,
    input logic              mem_we,
    input logic              mem_ce,
    input logic              done,
    input logic              busy
);
    // R5: output enable and write strobe are exclusive.
    a_r5_oe_we_excl: assert property (@(posedge clk) disable iff (!rst_n)
        !(mem_oe && mem_we));
    // R5: no data drive during a read.
    a_r5_no_drive_on_read: assert property (@(posedge clk) disable iff (!rst_n)
        mem_oe |-> !mem_dq_drv);
    // R3: address and data are steady while the strobe is high.
    a_r3_stable_under_we: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> ($stable(mem_addr) && $stable(mem_dq_out)));
    // R2: the strobe lasts one cycle and is framed by driven cycles.
    a_r2_we_one_cycle: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(mem_we) |=> (!mem_we && mem_dq_drv));
    a_r2_we_needs_drive: assert property (@(posedge clk) disable iff (!rst_n)
        mem_we |-> mem_dq_drv);
    // R9: chip enable and the top address bit never change.
    a_r9_ce_hi_bit: assert property (@(posedge clk) disable iff (!rst_n)
        mem_ce && (mem_addr[ADDR_W] == HI_ADDR_LEVEL));
    // R10: done is a single pulse and is never seen with busy.
    a_r10_done_pulse: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);
    a_r10_done_not_busy: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !busy);
    // R6: address holds for the whole of a busy period.
    a_r6_addr_held_busy: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(busy) && busy) |-> $stable(mem_addr));
endmodule

bind sram_access_ctrl sram_access_ctrl_chk #(
    .ADDR_W(ADDR_W), .DATA_W(DATA_W), .HI_ADDR_LEVEL(HI_ADDR_LEVEL)
) chk_i (
    .clk(clk), .rst_n(rst_n), .mem_addr(mem_addr), .mem_dq_out(mem_dq_out),
    .mem_dq_drv(mem_dq_drv), .mem_oe(mem_oe), .mem_we(mem_we),
    .mem_ce(mem_ce), .done(done), .busy(busy)
);

// File: tb/sram_access_ctrl_tb_top.sv
// Directed bench for sram_access_ctrl with a behavioural asynchronous RAM.
module sram_access_ctrl_tb_top;
    localparam int AW = 15;
    localparam int DW = 8;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          rd_req = 1'b0, wr_req = 1'b0;
    logic [AW-1:0] req_addr = '0;
    logic [DW-1:0] req_wdata = '0;
    logic [AW:0]   mem_addr;
    logic [DW-1:0] mem_dq_out, mem_dq_in, rd_data;
    logic          mem_dq_drv, mem_oe, mem_we, mem_ce, done, busy;

    int checks = 0;
    int failures = 0;
    int we_viol = 0;
    int cyc = 0;

    always #2 clk = ~clk;

    sram_access_ctrl dut_i (
        .clk(clk), .rst_n(rst_n), .rd_req(rd_req), .wr_req(wr_req),
        .req_addr(req_addr), .req_wdata(req_wdata), .mem_addr(mem_addr),
        .mem_dq_out(mem_dq_out), .mem_dq_drv(mem_dq_drv), .mem_dq_in(mem_dq_in),
        .mem_oe(mem_oe), .mem_we(mem_we), .mem_ce(mem_ce), .rd_data(rd_data),
        .done(done), .busy(busy)
    );

    // Behavioural asynchronous RAM (low 10 address bits decoded).
    logic [DW-1:0] mem [0:1023];
    initial for (int i = 0; i < 1024; i++) mem[i] = '0;
    always @(negedge mem_we) mem[mem_addr[9:0]] = mem_dq_out;
    assign #1 mem_dq_in = mem_oe ? mem[mem_addr[9:0]] : 'x;
    always @(mem_addr or mem_dq_out) if (mem_we === 1'b1) we_viol++;

    // Watchdog and cycle counter.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 20000) begin
            failures++;
            $display("FAIL watchdog expired act=%0d exp<=20000", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                       input logic [31:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    // Write sequence; noise raises both requests with a junk address while busy.
    task automatic do_write(input logic [AW-1:0] a, input logic [DW-1:0] d,
                            input bit also_rd, input bit noise);
        req_addr = a; req_wdata = d; wr_req = 1'b1; rd_req = also_rd;
        @(posedge clk); @(negedge clk);
        wr_req = noise; rd_req = noise;
        if (noise) begin req_addr = ~a; req_wdata = ~d; end
        chk(busy === 1'b1, "R10 busy after accept", busy, 1);
        chk(mem_we === 1'b0 && mem_dq_drv === 1'b1 && mem_oe === 1'b0,
            "R2 setup cycle", {mem_oe, mem_we, mem_dq_drv}, 3'b001);
        chk(mem_addr[AW-1:0] === a && mem_dq_out === d, "R3 setup addr/data",
            {mem_addr, mem_dq_out}, {1'b0, a, d});
        @(negedge clk);
        chk(mem_we === 1'b1 && mem_dq_drv === 1'b1 && mem_oe === 1'b0,
            "R2 strobe cycle", {mem_oe, mem_we, mem_dq_drv}, 3'b011);
        chk(mem_addr[AW-1:0] === a && mem_dq_out === d, "R3 strobe addr/data",
            {mem_addr, mem_dq_out}, {1'b0, a, d});
        @(negedge clk);
        chk(mem_we === 1'b0 && mem_dq_drv === 1'b1 && busy === 1'b1,
            "R2 hold cycle", {busy, mem_we, mem_dq_drv}, 3'b101);
        chk(mem_addr[AW-1:0] === a && mem_dq_out === d, "R3 hold addr/data",
            {mem_addr, mem_dq_out}, {1'b0, a, d});
        wr_req = 1'b0; rd_req = 1'b0;
        @(negedge clk);
        chk(done === 1'b1 && busy === 1'b0 && mem_dq_drv === 1'b0,
            "R10 write done", {done, busy, mem_dq_drv}, 3'b100);
        chk(mem_ce === 1'b1 && mem_addr[AW] === 1'b0, "R9 ce/top bit",
            {mem_ce, mem_addr[AW]}, 2'b10);
    endtask

    // Two-cycle read; checks capture and done timing.
    task automatic do_read(input logic [AW-1:0] a, input logic [DW-1:0] exp);
        req_addr = a; rd_req = 1'b1;
        @(posedge clk); @(negedge clk);
        rd_req = 1'b0;
        chk(mem_oe === 1'b1 && mem_we === 1'b0 && mem_dq_drv === 1'b0,
            "R5 read cycle 1", {mem_oe, mem_we, mem_dq_drv}, 3'b100);
        chk(mem_addr[AW-1:0] === a && busy === 1'b1, "R4 read addr",
            {busy, mem_addr}, {1'b1, 1'b0, a});
        @(negedge clk);
        chk(mem_oe === 1'b1 && mem_addr[AW-1:0] === a, "R4 read cycle 2",
            {mem_oe, mem_addr}, {1'b1, 1'b0, a});
        @(negedge clk);
        chk(done === 1'b1 && busy === 1'b0 && mem_oe === 1'b0, "R10 read done",
            {done, busy, mem_oe}, 3'b100);
        chk(rd_data === exp, "R4 read data", rd_data, exp);
    endtask

    task automatic t_reset();
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        chk({busy, done, mem_oe, mem_we, mem_dq_drv} === 5'b0, "R1 reset controls",
            {busy, done, mem_oe, mem_we, mem_dq_drv}, 0);
        rst_n = 1'b1;
        @(negedge clk); @(negedge clk);
        chk(rd_data === 8'h00 && mem_ce === 1'b1 && busy === 1'b0, "R1 idle after reset",
            {mem_ce, busy, rd_data}, {2'b10, 8'h00});
    endtask

    task automatic t_basic();
        do_write(15'h0012, 8'hA5, 1'b0, 1'b0);
        do_write(15'h0013, 8'h3C, 1'b0, 1'b0);
        @(negedge clk);
        chk(done === 1'b0, "R10 done one cycle", done, 0);
        do_read(15'h0012, 8'hA5);
        do_read(15'h0013, 8'h3C);
    endtask

    task automatic t_back_to_back();
        do_write(15'h0100, 8'h5A, 1'b0, 1'b0);
        do_write(15'h0101, 8'hC3, 1'b0, 1'b0);   // accepted in the done cycle
        do_read(15'h0100, 8'h5A);
        do_read(15'h0101, 8'hC3);
    endtask

    task automatic t_ignore_busy();
        do_write(15'h0020, 8'h77, 1'b0, 1'b1);
        // junk address ~0x0020 (low bits 0x3DF) must remain untouched
        do_read(~15'h0020, 8'h00);
        chk(mem[10'h3DF] === 8'h00, "R6 junk address untouched", mem[10'h3DF], 0);
        do_read(15'h0020, 8'h77);
    endtask

    task automatic t_both_req();
        do_write(15'h0030, 8'h99, 1'b1, 1'b0);
        do_read(15'h0030, 8'h99);
        chk(1'b1, "R7 write won", 0, 0);
    endtask

    task automatic t_hold_rd();
        do_read(15'h0012, 8'hA5);
        do_write(15'h0040, 8'h11, 1'b0, 1'b0);
        repeat (3) @(negedge clk);
        chk(rd_data === 8'hA5, "R8 rd_data held across write", rd_data, 8'hA5);
    endtask

    initial begin
        @(negedge clk);
        t_reset();
        t_basic();
        t_back_to_back();
        t_ignore_busy();
        t_both_req();
        t_hold_rd();
        chk(we_viol == 0, "R3 no bus change under strobe", we_viol, 0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end
endmodule